// File: doc/BRIEF.md
# Dual Eight-Bit Compare-Match Timer

This block holds two independent timer channels. Each channel has an up-counter and a compare constant. The counter advances on cycles where that channel's count-enable input is high. When the counter reaches the constant, the channel raises a sticky compare flag and applies a programmable action to its timer output pin. It can also restart its count period. Each channel has a selectable counter clear source and a sticky overflow flag that is set when the counter wraps past its all-ones value.

Software reaches every register through a small synchronous register bus. A byte access targets one channel. A word access targets the same register of both channels at once, so both counters, or both compare constants, can be loaded or sampled together in one transfer. Reads are combinational. Writes take effect at the next clock edge.

Top module: `cmtimer_pair`

## Requirements
- R1: After reset, every counter reads 0x00, every compare constant reads 0xFF, every control register and status register reads 0x00, and both timer outputs are low.
- R2: A counter increments by one at each clock edge where its count-enable input is high. It holds its value when count-enable is low and nothing writes or clears it.
- R3: Address bits [2:1] select the register kind: 00 counter, 01 compare constant, 10 control, 11 status. On a byte access, address bit 0 selects the channel (0 or 1) and data uses bits [7:0]; the byte read returns zero in bits [15:8]. On a word access, channel 0 uses bits [15:8] and channel 1 uses bits [7:0].
- R4: When a bus write to a counter and an increment of that counter fall in the same cycle, the written value is loaded.
- R5: Control bits [1:0] select the counter clear source. 00 means never cleared. 01 means the counter returns to 0x00 on the count cycle after it reaches the compare constant, so the period is the constant plus one. 10 means it returns to 0x00 on a count cycle where the compare-B event input is high. 11 means it returns to 0x00 in any cycle where the external clear input is high.
- R6: An increment from 0xFF to 0x00 sets status bit 0 (overflow).
- R7: The first cycle in which the counter equals the compare constant is a compare-A event, and it sets status bit 1 at the following edge. Further cycles in which the two values stay equal cause no new event.
- R8: No compare-A event occurs in a cycle in which the compare constant is being written.
- R9: Control bits [3:2] select the output action on a compare-A event, applied at the same edge that sets the flag: 00 hold, 01 drive low, 10 drive high, 11 toggle.
- R10: Status flags stay set until software clears them. Writing 0 to a flag bit clears it only if a status read since the last status write returned that bit as 1. Writing 1 to a flag bit has no effect.
- R11: If a flag's set event and its clear fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register kind in bits [2:1]; channel in bit 0 for byte access |
| busWord | input | 1 | 1 selects a word access to both channels |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe; arms flags for clearing |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data (combinational) |
| countEn | input | 2 | Per-channel count enable |
| extClr | input | 2 | Per-channel external clear request |
| cmpBEvt | input | 2 | Per-channel compare-B event |
| tmrOut | output | 2 | Per-channel timer output pin |

## Verification
Properties check several rules on every cycle. An idle counter holds its value, and a counter write lands exactly. The overflow flag can rise only after an increment from all-ones. A flag can fall only at a status write. The compare flag cannot rise right after a compare-constant write. A timer pin changes only together with a set compare flag. The directed scenarios cover what needs a known setup sequence: the constant-plus-one period, each output-action encoding, each clear source, the read-before-clear protocol, the word byte order, and the case where equality first appears during a compare write.

// File: rtl/cmtimer_pkg.sv
package cmtimer_pkg;

  typedef enum logic [1:0] {
    REG_CNT = 2'b00,
    REG_CMP = 2'b01,
    REG_CTL = 2'b10,
    REG_STS = 2'b11
  } regSel_e;

  typedef enum logic [1:0] {
    CLR_NONE    = 2'b00,
    CLR_MATCH_A = 2'b01,
    CLR_MATCH_B = 2'b10,
    CLR_EXT     = 2'b11
  } clrSel_e;

  typedef enum logic [1:0] {
    OUT_HOLD   = 2'b00,
    OUT_LOW    = 2'b01,
    OUT_HIGH   = 2'b10,
    OUT_TOGGLE = 2'b11
  } outSel_e;

  // Per-channel strobes produced by the bus decoder.
  typedef struct packed {
    logic wrCnt;
    logic wrCmp;
    logic wrCtl;
    logic wrSts;
    logic rdSts;
  } chStrobe_t;

  localparam int unsigned STS_OVF = 0;
  localparam int unsigned STS_CMA = 1;

endpackage

// File: rtl/cmtimer_bus.sv
module cmtimer_bus
  import cmtimer_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [2:0]                   busAddr,
  input  logic                         busWord,
  input  logic                         busWr,
  input  logic                         busRd,
  input  logic [2*DATA_W-1:0]          busWdata,
  output logic [2*DATA_W-1:0]          busRdata,
  output chStrobe_t [1:0]              stb,
  output logic [1:0][DATA_W-1:0]       wrData,
  input  logic [1:0][DATA_W-1:0]       cntQ,
  input  logic [1:0][DATA_W-1:0]       cmpQ,
  input  logic [1:0][DATA_W-1:0]       ctlQ,
  input  logic [1:0][DATA_W-1:0]       stsQ
);

  localparam int unsigned N_CH = 2;

  regSel_e regSel;
  logic [N_CH-1:0][DATA_W-1:0] chRd;

  assign regSel = regSel_e'(busAddr[2:1]);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic hit;
    assign hit = busWord | (busAddr[0] == (ch == 1));

    always_comb begin
      stb[ch].wrCnt = busWr & hit & (regSel == REG_CNT);
      stb[ch].wrCmp = busWr & hit & (regSel == REG_CMP);
      stb[ch].wrCtl = busWr & hit & (regSel == REG_CTL);
      stb[ch].wrSts = busWr & hit & (regSel == REG_STS);
      stb[ch].rdSts = busRd & hit & (regSel == REG_STS);
    end

    // Word access: channel 0 in the upper byte lane.
    assign wrData[ch] = busWord ? busWdata[(N_CH-1-ch)*DATA_W +: DATA_W]
                                : busWdata[DATA_W-1:0];

    always_comb begin
      unique case (regSel)
        REG_CNT: chRd[ch] = cntQ[ch];
        REG_CMP: chRd[ch] = cmpQ[ch];
        REG_CTL: chRd[ch] = ctlQ[ch];
        default: chRd[ch] = stsQ[ch];
      endcase
    end
  end

  always_comb begin
    if (busWord) busRdata = {chRd[0], chRd[1]};
    else         busRdata = {{DATA_W{1'b0}}, chRd[busAddr[0]]};
  end

endmodule

// File: rtl/cmtimer_chan.sv
module cmtimer_chan
  import cmtimer_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              countEn,
  input  logic              extClr,
  input  logic              cmpBEvt,
  output logic [DATA_W-1:0] cntQ,
  output logic [DATA_W-1:0] cmpQ,
  output logic [DATA_W-1:0] ctlQ,
  output logic [DATA_W-1:0] stsQ,
  output logic              tmrOut
);

  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] cmp;
  clrSel_e           clrSel;
  outSel_e           outSel;
  logic              ovfFlag, cmaFlag;
  logic              ovfArm, cmaArm;
  logic              eqLast;
  logic              outQ;

  logic eqNow, eqGated, matchA, extClrNow, countClr, wrapNow, ovfClr, cmaClr;

  always_comb begin
    eqNow     = (cnt == cmp);
    // Comparison is blocked while the constant is being written.
    eqGated   = eqNow & ~stb.wrCmp;
    matchA    = eqGated & ~eqLast;
    extClrNow = (clrSel == CLR_EXT) & extClr;
    countClr  = countEn & (((clrSel == CLR_MATCH_A) & eqGated) |
                           ((clrSel == CLR_MATCH_B) & cmpBEvt));
    wrapNow   = countEn & ~stb.wrCnt & ~extClrNow & ~countClr &
                (cnt == {DATA_W{1'b1}});
    ovfClr    = stb.wrSts & ~wrData[STS_OVF] & ovfArm;
    cmaClr    = stb.wrSts & ~wrData[STS_CMA] & cmaArm;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (stb.wrCnt)     cnt <= wrData;
    else if (extClrNow)     cnt <= '0;
    else if (countClr)      cnt <= '0;
    else if (countEn)       cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          cmp <= '1;
    else if (stb.wrCmp) cmp <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrSel <= CLR_NONE;
      outSel <= OUT_HOLD;
    end else if (stb.wrCtl) begin
      clrSel <= clrSel_e'(wrData[1:0]);
      outSel <= outSel_e'(wrData[3:2]);
    end
  end

  // Sticky flags: set has priority over an armed clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      cmaFlag <= 1'b0;
    end else begin
      ovfFlag <= wrapNow | (ovfFlag & ~ovfClr);
      cmaFlag <= matchA  | (cmaFlag & ~cmaClr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfArm <= 1'b0;
      cmaArm <= 1'b0;
    end else if (stb.wrSts) begin
      ovfArm <= 1'b0;
      cmaArm <= 1'b0;
    end else if (stb.rdSts) begin
      ovfArm <= ovfArm | ovfFlag;
      cmaArm <= cmaArm | cmaFlag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) eqLast <= 1'b0;
    else       eqLast <= eqGated;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outQ <= 1'b0;
    else if (matchA) begin
      unique case (outSel)
        OUT_LOW:    outQ <= 1'b0;
        OUT_HIGH:   outQ <= 1'b1;
        OUT_TOGGLE: outQ <= ~outQ;
        default:    outQ <= outQ;
      endcase
    end
  end

  assign cntQ   = cnt;
  assign cmpQ   = cmp;
  assign ctlQ   = DATA_W'({outSel, clrSel});
  assign stsQ   = DATA_W'({cmaFlag, ovfFlag});
  assign tmrOut = outQ;

endmodule

// File: rtl/cmtimer_pair.sv
module cmtimer_pair
  import cmtimer_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          busAddr,
  input  logic                busWord,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [2*DATA_W-1:0] busWdata,
  output logic [2*DATA_W-1:0] busRdata,
  input  logic [1:0]          countEn,
  input  logic [1:0]          extClr,
  input  logic [1:0]          cmpBEvt,
  output logic [1:0]          tmrOut
);

  localparam int unsigned N_CH = 2;

  chStrobe_t [N_CH-1:0]         stb;
  logic [N_CH-1:0][DATA_W-1:0]  wrData;
  logic [N_CH-1:0][DATA_W-1:0]  cntQ;
  logic [N_CH-1:0][DATA_W-1:0]  cmpQ;
  logic [N_CH-1:0][DATA_W-1:0]  ctlQ;
  logic [N_CH-1:0][DATA_W-1:0]  stsQ;

  cmtimer_bus #(.DATA_W(DATA_W)) u_bus (
    .busAddr  (busAddr),
    .busWord  (busWord),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .stb      (stb),
    .wrData   (wrData),
    .cntQ     (cntQ),
    .cmpQ     (cmpQ),
    .ctlQ     (ctlQ),
    .stsQ     (stsQ)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    cmtimer_chan #(.DATA_W(DATA_W)) u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .stb     (stb[ch]),
      .wrData  (wrData[ch]),
      .countEn (countEn[ch]),
      .extClr  (extClr[ch]),
      .cmpBEvt (cmpBEvt[ch]),
      .cntQ    (cntQ[ch]),
      .cmpQ    (cmpQ[ch]),
      .ctlQ    (ctlQ[ch]),
      .stsQ    (stsQ[ch]),
      .tmrOut  (tmrOut[ch])
    );
  end

endmodule

// File: rtl/cmtimer_pair_chk.sv
module cmtimer_pair_chk
  import cmtimer_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input chStrobe_t [1:0]             stb,
  input logic [1:0][DATA_W-1:0]      wrData,
  input logic [1:0][DATA_W-1:0]      cntQ,
  input logic [1:0][DATA_W-1:0]      ctlQ,
  input logic [1:0][DATA_W-1:0]      stsQ,
  input logic [1:0]                  countEn,
  input logic [1:0]                  extClr,
  input logic [1:0]                  tmrOut
);

  for (genvar i = 0; i < 2; i++) begin : g_ch
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!countEn[i] && !stb[i].wrCnt && !(ctlQ[i][1:0] == 2'b11 && extClr[i]))
      |=> $stable(cntQ[i]));

    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rstN)
      stb[i].wrCnt |=> (cntQ[i] == $past(wrData[i])));

    a_r6_ovf_after_wrap: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stsQ[i][STS_OVF]) |-> $past(countEn[i] && (cntQ[i] == {DATA_W{1'b1}})));

    a_r10_ovf_falls_on_write: assert property (@(posedge clk) disable iff (!rstN)
      $fell(stsQ[i][STS_OVF]) |-> $past(stb[i].wrSts));

    a_r10_cma_falls_on_write: assert property (@(posedge clk) disable iff (!rstN)
      $fell(stsQ[i][STS_CMA]) |-> $past(stb[i].wrSts));

    a_r8_no_match_on_cmp_write: assert property (@(posedge clk) disable iff (!rstN)
      (stb[i].wrCmp && !stsQ[i][STS_CMA]) |=> !stsQ[i][STS_CMA]);

    a_r9_pin_moves_with_flag: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(tmrOut[i]) |-> stsQ[i][STS_CMA]);
  end

endmodule

bind cmtimer_pair cmtimer_pair_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .stb     (stb),
  .wrData  (wrData),
  .cntQ    (cntQ),
  .ctlQ    (ctlQ),
  .stsQ    (stsQ),
  .countEn (countEn),
  .extClr  (extClr),
  .tmrOut  (tmrOut)
);

// File: tb/tb_cmtimer_pair.sv
module tb_cmtimer_pair;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWord = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [1:0]  countEn = '0;
  logic [1:0]  extClr = '0;
  logic [1:0]  cmpBEvt = '0;
  logic [1:0]  tmrOut;

  int checks = 0;
  int fails = 0;

  cmtimer_pair dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWord(busWord),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .countEn(countEn), .extClr(extClr), .cmpBEvt(cmpBEvt), .tmrOut(tmrOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Address map: [2:1] kind, [0] channel.
  localparam logic [2:0] A_CNT0 = 3'b000, A_CNT1 = 3'b001;
  localparam logic [2:0] A_CMP0 = 3'b010, A_CMP1 = 3'b011;
  localparam logic [2:0] A_CTL0 = 3'b100, A_CTL1 = 3'b101;
  localparam logic [2:0] A_STS0 = 3'b110, A_STS1 = 3'b111;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic busWrite(input logic [2:0] a, input logic w, input logic [15:0] d);
    busAddr = a; busWord = w; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWord = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, input logic w, output logic [15:0] d);
    busAddr = a; busWord = w; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0; busWord = 1'b0;
  endtask

  task automatic tick(input logic [1:0] en, input int n);
    countEn = en;
    repeat (n) @(negedge clk);
    countEn = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    busRead(A_CNT0, 1'b1, d); check("R1 counters", d, 16'h0000);
    busRead(A_CMP0, 1'b1, d); check("R1 compare", d, 16'hFFFF);
    busRead(A_CTL0, 1'b1, d); check("R1 control", d, 16'h0000);
    busRead(A_STS0, 1'b1, d); check("R1 status", d, 16'h0000);
    check("R1 outputs", {14'h0, tmrOut}, 16'h0000);
  endtask

  task automatic t_count();
    logic [15:0] d;
    tick(2'b01, 5);
    busRead(A_CNT0, 1'b0, d); check("R2 ch0 count 5, R3 byte lane", d, 16'h0005);
    busRead(A_CNT1, 1'b0, d); check("R2 ch1 idle hold", d, 16'h0000);
  endtask

  task automatic t_word();
    logic [15:0] d;
    busWrite(A_CNT0, 1'b1, 16'h1234);
    busRead(A_CNT0, 1'b0, d); check("R3 word hi -> ch0", d, 16'h0012);
    busRead(A_CNT1, 1'b0, d); check("R3 word lo -> ch1", d, 16'h0034);
    busWrite(A_CMP0, 1'b1, 16'hA55A);
    busRead(A_CMP1, 1'b0, d); check("R3 cmp ch1", d, 16'h005A);
  endtask

  task automatic t_write_wins();
    logic [15:0] d;
    countEn = 2'b01;
    busWrite(A_CNT0, 1'b0, 16'h0040);
    countEn = '0;
    busRead(A_CNT0, 1'b0, d); check("R4 write beats increment", d, 16'h0040);
  endtask

  task automatic t_match_clear();
    logic [15:0] d;
    busWrite(A_CTL0, 1'b0, 16'h0009);   // clear on A, out high
    busWrite(A_CMP0, 1'b0, 16'h0003);
    busWrite(A_CNT0, 1'b0, 16'h0000);
    tick(2'b01, 3);
    busRead(A_CNT0, 1'b0, d); check("R2 reached constant", d, 16'h0003);
    tick(2'b01, 1);
    busRead(A_CNT0, 1'b0, d); check("R5 cleared after cmp+1", d, 16'h0000);
    busRead(A_STS0, 1'b0, d); check("R7 cma flag", d, 16'h0002);
    check("R9 out high", {15'h0, tmrOut[0]}, 16'h0001);
    tick(2'b01, 4);
    busRead(A_CNT0, 1'b0, d); check("R5 second period", d, 16'h0000);
  endtask

  task automatic t_out_modes();
    busWrite(A_CTL0, 1'b0, 16'h0005); tick(2'b01, 4);
    check("R9 drive low", {15'h0, tmrOut[0]}, 16'h0000);
    busWrite(A_CTL0, 1'b0, 16'h000D); tick(2'b01, 4);
    check("R9 toggle to 1", {15'h0, tmrOut[0]}, 16'h0001);
    tick(2'b01, 4);
    check("R9 toggle to 0", {15'h0, tmrOut[0]}, 16'h0000);
    busWrite(A_CTL0, 1'b0, 16'h0001); tick(2'b01, 4);
    check("R9 hold", {15'h0, tmrOut[0]}, 16'h0000);
  endtask

  task automatic t_flag_clear();
    logic [15:0] d;
    busWrite(A_STS0, 1'b0, 16'h00FF);   // disarms, writes 1s
    busRead(A_STS0, 1'b0, d); check("R10 write 1 no effect", d, 16'h0002);
    busWrite(A_STS0, 1'b0, 16'h0000);   // arm removed by the write above? read re-armed
    busRead(A_STS0, 1'b0, d); check("R10 clear after read", d, 16'h0000);
    busWrite(A_CNT0, 1'b0, 16'h0002);
    tick(2'b01, 1);                     // 2 -> 3 equals constant
    tick(2'b00, 1);                     // match event cycle
    busWrite(A_STS0, 1'b0, 16'h0000);   // no read since last write
    busRead(A_STS0, 1'b0, d); check("R10 unarmed write keeps flag", d, 16'h0002);
  endtask

  task automatic t_overflow();
    logic [15:0] d;
    busWrite(A_CNT1, 1'b0, 16'h00FF);
    tick(2'b10, 1);
    busRead(A_CNT1, 1'b0, d); check("R6 wrapped", d, 16'h0000);
    busRead(A_STS1, 1'b0, d); check("R6 ovf flag", d, 16'h0001);
  endtask

  task automatic t_set_priority();
    logic [15:0] d;
    busWrite(A_CNT1, 1'b0, 16'h00FF);
    busRead(A_STS1, 1'b0, d);           // arm
    countEn = 2'b10;
    busWrite(A_STS1, 1'b0, 16'h0000);
    countEn = '0;
    busRead(A_STS1, 1'b0, d); check("R11 set beats clear", d, 16'h0001);
  endtask

  task automatic t_ext_clear();
    logic [15:0] d;
    busWrite(A_CTL1, 1'b0, 16'h0000);
    busWrite(A_CNT1, 1'b0, 16'h0020);
    extClr = 2'b10; @(negedge clk); extClr = '0;
    busRead(A_CNT1, 1'b0, d); check("R5 ext ignored when select 00", d, 16'h0020);
    busWrite(A_CTL1, 1'b0, 16'h0003);
    extClr = 2'b10; @(negedge clk); extClr = '0;
    busRead(A_CNT1, 1'b0, d); check("R5 ext clear", d, 16'h0000);
  endtask

  task automatic t_cmpb_clear();
    logic [15:0] d;
    busWrite(A_CTL1, 1'b0, 16'h0002);
    busWrite(A_CNT1, 1'b0, 16'h0030);
    cmpBEvt = 2'b10; @(negedge clk); cmpBEvt = '0;
    busRead(A_CNT1, 1'b0, d); check("R5 cmpB needs count cycle", d, 16'h0030);
    cmpBEvt = 2'b10; countEn = 2'b10; @(negedge clk); cmpBEvt = '0; countEn = '0;
    busRead(A_CNT1, 1'b0, d); check("R5 cmpB clear", d, 16'h0000);
  endtask

  task automatic t_inhibit();
    logic [15:0] d;
    logic        outBefore;
    busRead(A_STS0, 1'b0, d);           // arm
    busWrite(A_STS0, 1'b0, 16'h0000);
    busWrite(A_CTL0, 1'b0, 16'h000C);   // no clear, toggle
    busWrite(A_CMP0, 1'b0, 16'h0006);
    busWrite(A_CNT0, 1'b0, 16'h0005);
    busRead(A_STS0, 1'b0, d); check("R8 setup flag clear", d, 16'h0000);
    outBefore = tmrOut[0];
    tick(2'b01, 1);                     // counter becomes 6
    busWrite(A_CMP0, 1'b0, 16'h0009);   // equality first seen in write cycle
    busRead(A_STS0, 1'b0, d); check("R8 no event during cmp write", d, 16'h0000);
    check("R8 pin unchanged", {15'h0, tmrOut[0]}, {15'h0, outBefore});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_count();
    t_word();
    t_write_wins();
    t_match_clear();
    t_out_modes();
    t_flag_clear();
    t_overflow();
    t_set_priority();
    t_ext_clear();
    t_cmpb_clear();
    t_inhibit();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule